// File: doc/BRIEF.md
# Autovectored Interrupt Acceptance Unit

This unit sits on the processor side of an interrupt line bundle. A 3-bit priority level arrives from an external interrupt controller; the unit filters it, compares it against the priority mask held in the processor status, and decides whether to take the interrupt. When it takes one, it forms the address of the autovector table entry for that level, relocated by a base register, and raises the mask to the accepted level while forcing supervisor mode.

On acceptance the unit pulses `accept_o` for one cycle. In the same cycle it presents the vector address, the status word as it stood before the update, and the program counter to be pushed. The surrounding core performs the stack push and the 32-bit handler fetch. It then returns the fetched word on `fetch_data_i` with `fetch_done_i`, and the unit turns that word into a program-counter load. Until that return arrives the unit takes no further interrupt. Level 7 is treated as non-maskable: a fresh rise to 7 is taken even when the mask already reads 7.

Top module: `irq_accept_unit`

## Requirements
- R1: A level on `ipl_i` is evaluated only once two consecutive clock samples agree. A level that changes every cycle is never taken. A level held from just before edge k gives `accept_o` high after edge k+2.
- R2: Levels 1 to 6 are taken only when strictly greater than the current mask, and level 0 is never taken.
- R3: On acceptance of level L, `vec_addr_o` equals the base register plus 4*(24+L), which gives offsets 0x64 for level 1 through 0x7C for level 7.
- R4: On acceptance, `super_o` becomes 1 and `mask_o` becomes L. `saved_sr_o` carries the prior status with supervisor at bit 13 and mask at bits 10:8, all other bits zero, and `saved_pc_o` carries `pc_i` from the accepting cycle.
- R5: A rise of the filtered level to 7 is taken even when the mask is 7. A level held at 7 is taken only once, and another acceptance needs the level to leave 7 and return.
- R6: After an acceptance, no further acceptance occurs until `fetch_done_i` is seen. The cycle after `fetch_done_i`, `pc_load_o` pulses with `pc_new_o` equal to that cycle's `fetch_data_i`. `fetch_done_i` has no effect while no acceptance is outstanding.
- R7: A write on `vbr_wr_i` changes the base register only when `super_o` is 1. The base register is zero after reset.
- R8: After reset, `super_o` is 1, `mask_o` is 7, and `accept_o` and `pc_load_o` are 0.
- R9: `sr_wr_i` loads supervisor from bit 13 and mask from bits 10:8 of `sr_wdata_i`. An acceptance in the same cycle takes precedence over the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ipl_i | input | 3 | Requested priority level, 0 = none |
| pc_i | input | 32 | Current program counter, captured on acceptance |
| sr_wr_i | input | 1 | Status write strobe |
| sr_wdata_i | input | 16 | Status write data |
| vbr_wr_i | input | 1 | Base register write strobe |
| vbr_wdata_i | input | 32 | Base register write data |
| fetch_done_i | input | 1 | Handler fetch completed |
| fetch_data_i | input | 32 | Fetched handler address |
| accept_o | output | 1 | One-cycle acceptance pulse |
| vec_addr_o | output | 32 | Vector table address to fetch |
| saved_sr_o | output | 16 | Status word to push |
| saved_pc_o | output | 32 | Program counter to push |
| pc_load_o | output | 1 | One-cycle program counter load |
| pc_new_o | output | 32 | New program counter value |
| super_o | output | 1 | Supervisor mode flag |
| mask_o | output | 3 | Current priority mask |

## Verification
The bench aims at the equal-to-mask boundary. A design that compared with "greater or equal" would take a level that matches the mask and would reenter its own handler. It toggles the level every cycle to show that the stability filter never lets a glitching level through, and it counts the cycles to the first acceptance so that an extra or a missing register stage is visible. Level 7 is held across a full acceptance sequence at mask 7: a level-sensitive rather than edge-sensitive bypass would take it again and again. A base register write in user mode is shown to leave later vector addresses unchanged.

// File: rtl/irq_accept_pkg.sv
package irq_accept_pkg;

    typedef struct packed {
        logic       sup;
        logic [2:0] mask;
    } irq_stat_t;

    localparam int unsigned SR_SUP_BIT  = 13;
    localparam int unsigned SR_MASK_LSB = 8;

endpackage

// File: rtl/irq_level_filter.sv
module irq_level_filter #(
    parameter int unsigned LVL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LVL_W-1:0] lvl_i,
    output logic [LVL_W-1:0] lvl_o,
    output logic             top_rise_o
);
    localparam logic [LVL_W-1:0] TOP = {LVL_W{1'b1}};

    typedef struct packed {
        logic [LVL_W-1:0] smp;
        logic [LVL_W-1:0] stab;
        logic             top_prev;
    } flt_t;

    flt_t st_q, st_d;

    always_comb begin
        st_d          = st_q;
        st_d.smp      = lvl_i;
        if (lvl_i == st_q.smp) begin
            st_d.stab = lvl_i;
        end
        st_d.top_prev = (st_q.stab == TOP);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign lvl_o      = st_q.stab;
    assign top_rise_o = (st_q.stab == TOP) && !st_q.top_prev;

endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
    parameter int unsigned LVL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LVL_W-1:0] lvl_i,
    input  logic             top_rise_i,
    input  logic [LVL_W-1:0] mask_i,
    input  logic             busy_i,
    output logic             take_o
);
    localparam logic [LVL_W-1:0] TOP = {LVL_W{1'b1}};

    typedef struct packed {
        logic pend;
    } arb_t;

    arb_t st_q, st_d;
    logic at_top;
    logic top_ok;
    logic over_mask;

    always_comb begin
        at_top    = (lvl_i == TOP);
        top_ok    = at_top && (st_q.pend || top_rise_i);
        over_mask = (lvl_i > mask_i);
        take_o    = !busy_i && (lvl_i != '0) && (over_mask || top_ok);
        st_d      = st_q;
        st_d.pend = top_ok && !take_o;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/irq_vector_gen.sv
module irq_vector_gen #(
    parameter int unsigned LVL_W   = 3,
    parameter int unsigned ADDR_W  = 32,
    parameter int unsigned VEC_BASE = 24
) (
    input  logic [ADDR_W-1:0] base_i,
    input  logic [LVL_W-1:0]  lvl_i,
    output logic [ADDR_W-1:0] addr_o
);
    localparam int unsigned ENTRY_SHIFT = 2;

    logic [ADDR_W-1:0] vec_num;

    always_comb begin
        vec_num = ADDR_W'(VEC_BASE) + ADDR_W'(lvl_i);
        addr_o  = base_i + (vec_num << ENTRY_SHIFT);
    end

endmodule

// File: rtl/irq_accept_unit.sv
module irq_accept_unit
    import irq_accept_pkg::*;
#(
    parameter int unsigned ADDR_W   = 32,
    parameter int unsigned SR_W     = 16,
    parameter int unsigned VEC_BASE = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        ipl_i,
    input  logic [ADDR_W-1:0] pc_i,
    input  logic              sr_wr_i,
    input  logic [SR_W-1:0]   sr_wdata_i,
    input  logic              vbr_wr_i,
    input  logic [ADDR_W-1:0] vbr_wdata_i,
    input  logic              fetch_done_i,
    input  logic [ADDR_W-1:0] fetch_data_i,
    output logic              accept_o,
    output logic [ADDR_W-1:0] vec_addr_o,
    output logic [SR_W-1:0]   saved_sr_o,
    output logic [ADDR_W-1:0] saved_pc_o,
    output logic              pc_load_o,
    output logic [ADDR_W-1:0] pc_new_o,
    output logic              super_o,
    output logic [2:0]        mask_o
);
    localparam int unsigned LVL_W = 3;

    typedef struct packed {
        irq_stat_t         stat;
        logic [ADDR_W-1:0] vbr;
        logic              busy;
        logic              acc;
        logic [ADDR_W-1:0] vec;
        logic [SR_W-1:0]   ssr;
        logic [ADDR_W-1:0] spc;
        logic              load;
        logic [ADDR_W-1:0] pcnew;
    } unit_t;

    unit_t st_q, st_d;

    logic [LVL_W-1:0]  lvl_stab;
    logic              top_rise;
    logic              take;
    logic [ADDR_W-1:0] vec_calc;

    irq_level_filter #(.LVL_W(LVL_W)) u_filter (
        .clk        (clk),
        .rst_n      (rst_n),
        .lvl_i      (ipl_i),
        .lvl_o      (lvl_stab),
        .top_rise_o (top_rise)
    );

    irq_arbiter #(.LVL_W(LVL_W)) u_arb (
        .clk        (clk),
        .rst_n      (rst_n),
        .lvl_i      (lvl_stab),
        .top_rise_i (top_rise),
        .mask_i     (st_q.stat.mask),
        .busy_i     (st_q.busy),
        .take_o     (take)
    );

    irq_vector_gen #(
        .LVL_W    (LVL_W),
        .ADDR_W   (ADDR_W),
        .VEC_BASE (VEC_BASE)
    ) u_vec (
        .base_i (st_q.vbr),
        .lvl_i  (lvl_stab),
        .addr_o (vec_calc)
    );

    always_comb begin
        st_d      = st_q;
        st_d.acc  = 1'b0;
        st_d.load = 1'b0;

        if (vbr_wr_i && st_q.stat.sup) begin
            st_d.vbr = vbr_wdata_i;
        end

        if (take) begin
            st_d.acc                   = 1'b1;
            st_d.vec                   = vec_calc;
            st_d.ssr                   = '0;
            st_d.ssr[SR_SUP_BIT]       = st_q.stat.sup;
            st_d.ssr[SR_MASK_LSB +: 3] = st_q.stat.mask;
            st_d.spc                   = pc_i;
            st_d.stat.sup              = 1'b1;
            st_d.stat.mask             = lvl_stab;
            st_d.busy                  = 1'b1;
        end else begin
            if (sr_wr_i) begin
                st_d.stat.sup  = sr_wdata_i[SR_SUP_BIT];
                st_d.stat.mask = sr_wdata_i[SR_MASK_LSB +: 3];
            end
            if (st_q.busy && fetch_done_i) begin
                st_d.load  = 1'b1;
                st_d.pcnew = fetch_data_i;
                st_d.busy  = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q           <= '0;
            st_q.stat.sup  <= 1'b1;
            st_q.stat.mask <= 3'd7;
        end else begin
            st_q <= st_d;
        end
    end

    assign accept_o   = st_q.acc;
    assign vec_addr_o = st_q.vec;
    assign saved_sr_o = st_q.ssr;
    assign saved_pc_o = st_q.spc;
    assign pc_load_o  = st_q.load;
    assign pc_new_o   = st_q.pcnew;
    assign super_o    = st_q.stat.sup;
    assign mask_o     = st_q.stat.mask;

endmodule

// File: rtl/irq_accept_unit_chk.sv
module irq_accept_unit_chk #(
    parameter int unsigned SR_W = 16
) (
    input logic            clk,
    input logic            rst_n,
    input logic            accept_o,
    input logic            pc_load_o,
    input logic            fetch_done_i,
    input logic            super_o,
    input logic [2:0]      mask_o,
    input logic [SR_W-1:0] saved_sr_o
);
    logic inflight_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            inflight_q <= 1'b0;
        end else if (accept_o) begin
            inflight_q <= 1'b1;
        end else if (pc_load_o) begin
            inflight_q <= 1'b0;
        end
    end

    // R4: supervisor mode entered on acceptance
    a_r4_super_on_accept: assert property (@(posedge clk) disable iff (!rst_n)
        accept_o |-> super_o);

    // R2: mask climbs to the accepted level, except the level-7 bypass
    a_r2_mask_rises: assert property (@(posedge clk) disable iff (!rst_n)
        accept_o |-> ((saved_sr_o[10:8] < mask_o) || (mask_o == 3'd7)));

    // R6: no acceptance while a previous one is outstanding
    a_r6_no_accept_in_flight: assert property (@(posedge clk) disable iff (!rst_n)
        accept_o |-> !inflight_q);

    // R6: acceptance is a single-cycle pulse
    a_r6_accept_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        accept_o |=> !accept_o);

    // R6: a program counter load follows a completed fetch
    a_r6_load_after_fetch: assert property (@(posedge clk) disable iff (!rst_n)
        pc_load_o |-> (inflight_q && $past(fetch_done_i)));

endmodule

bind irq_accept_unit irq_accept_unit_chk #(.SR_W(SR_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .accept_o     (accept_o),
    .pc_load_o    (pc_load_o),
    .fetch_done_i (fetch_done_i),
    .super_o      (super_o),
    .mask_o       (mask_o),
    .saved_sr_o   (saved_sr_o)
);

// File: tb/irq_accept_unit_test.sv
`timescale 1ns/1ps
module irq_accept_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  ipl_i = '0;
    logic [31:0] pc_i = 32'h0000_4000;
    logic        sr_wr_i = 1'b0;
    logic [15:0] sr_wdata_i = '0;
    logic        vbr_wr_i = 1'b0;
    logic [31:0] vbr_wdata_i = '0;
    logic        fetch_done_i = 1'b0;
    logic [31:0] fetch_data_i = '0;
    logic        accept_o, pc_load_o, super_o;
    logic [31:0] vec_addr_o, saved_pc_o, pc_new_o;
    logic [15:0] saved_sr_o;
    logic [2:0]  mask_o;

    int n_cmp = 0;
    int n_bad = 0;
    int acc_cnt = 0;
    logic [31:0] last_vec = '0;
    bit done = 0;

    always #2 clk = ~clk;

    irq_accept_unit uut (
        .clk(clk), .rst_n(rst_n), .ipl_i(ipl_i), .pc_i(pc_i),
        .sr_wr_i(sr_wr_i), .sr_wdata_i(sr_wdata_i),
        .vbr_wr_i(vbr_wr_i), .vbr_wdata_i(vbr_wdata_i),
        .fetch_done_i(fetch_done_i), .fetch_data_i(fetch_data_i),
        .accept_o(accept_o), .vec_addr_o(vec_addr_o), .saved_sr_o(saved_sr_o),
        .saved_pc_o(saved_pc_o), .pc_load_o(pc_load_o), .pc_new_o(pc_new_o),
        .super_o(super_o), .mask_o(mask_o)
    );

    task automatic check(string req, string what, longint act, longint exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // behavioural reference
    int m_smp, m_stab, m_prev7, m_pend, m_busy, m_mask, m_sup, m_acc, m_load, m_ssr;
    logic [31:0] m_vbr, m_vec, m_spc, m_pcnew;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_smp = 0; m_stab = 0; m_prev7 = 0; m_pend = 0; m_busy = 0;
            m_mask = 7; m_sup = 1; m_acc = 0; m_load = 0; m_ssr = 0;
            m_vbr = 0; m_vec = 0; m_spc = 0; m_pcnew = 0;
        end else begin
            int rise, elig, take, old_sup;
            old_sup = m_sup;
            rise = (m_stab == 7 && !m_prev7);
            elig = (m_stab == 7) && (m_pend || rise);
            take = !m_busy && m_stab != 0 && (m_stab > m_mask || elig);
            m_acc = take; m_load = 0;
            if (take) begin
                m_vec = m_vbr + 32'(4 * (24 + m_stab));
                m_ssr = (m_sup << 13) | (m_mask << 8);
                m_spc = pc_i; m_sup = 1; m_mask = m_stab; m_busy = 1;
            end else begin
                if (sr_wr_i) begin
                    m_sup = int'(sr_wdata_i[13]);
                    m_mask = int'(sr_wdata_i[10:8]);
                end
                if (m_busy && fetch_done_i) begin
                    m_load = 1; m_pcnew = fetch_data_i; m_busy = 0;
                end
            end
            if (vbr_wr_i && old_sup) m_vbr = vbr_wdata_i;
            m_pend = elig && !take;
            m_prev7 = (m_stab == 7);
            if (int'(ipl_i) == m_smp) m_stab = int'(ipl_i);
            m_smp = int'(ipl_i);
        end
        #1;
        if (rst_n) begin
            check("R2", "accept_o", accept_o, m_acc);
            check("R4", "mask_o", mask_o, m_mask);
            check("R4", "super_o", super_o, m_sup);
            check("R6", "pc_load_o", pc_load_o, m_load);
            if (m_acc) begin
                check("R3", "vec_addr_o", vec_addr_o, m_vec);
                check("R4", "saved_sr_o", saved_sr_o, m_ssr);
                check("R4", "saved_pc_o", saved_pc_o, m_spc);
            end
            if (m_load) check("R6", "pc_new_o", pc_new_o, m_pcnew);
            if (accept_o) begin acc_cnt++; last_vec = vec_addr_o; end
        end
    end

    task automatic cycles(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic sr_write(logic [15:0] v);
        @(negedge clk); sr_wr_i = 1; sr_wdata_i = v;
        @(negedge clk); sr_wr_i = 0;
    endtask

    task automatic vbr_write(logic [31:0] v);
        @(negedge clk); vbr_wr_i = 1; vbr_wdata_i = v;
        @(negedge clk); vbr_wr_i = 0;
    endtask

    task automatic fetch(logic [31:0] v);
        @(negedge clk); fetch_done_i = 1; fetch_data_i = v;
        @(negedge clk); fetch_done_i = 0;
    endtask

    initial begin
        int base;
        cycles(3);
        rst_n = 1;
        @(posedge clk); #1;
        check("R8", "reset mask", mask_o, 7);
        check("R8", "reset super", super_o, 1);
        check("R8", "reset accept", accept_o, 0);
        check("R8", "reset load", pc_load_o, 0);
        vbr_write(32'h0000_1000);
        sr_write(16'h2200);
        check("R9", "mask after write", mask_o, 2);

        base = acc_cnt;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk); ipl_i = (i % 2 == 0) ? 3'd5 : 3'd0;
        end
        @(negedge clk); ipl_i = 0; cycles(3);
        check("R1", "glitching level accepts", acc_cnt - base, 0);

        base = acc_cnt;
        ipl_i = 3'd1; cycles(6);
        ipl_i = 3'd2; cycles(6);
        check("R2", "accepts at or below mask", acc_cnt - base, 0);

        pc_i = 32'h0000_5A5A;
        ipl_i = 3'd3;
        @(posedge clk); #1; check("R1", "accept after edge k", accept_o, 0);
        @(posedge clk); #1; check("R1", "accept after edge k+1", accept_o, 0);
        @(posedge clk); #1; check("R1", "accept after edge k+2", accept_o, 1);
        check("R3", "level 3 vector", last_vec, 32'h0000_106C);

        base = acc_cnt;
        @(negedge clk); ipl_i = 3'd5; cycles(6);
        check("R6", "accepts while outstanding", acc_cnt - base, 0);
        fetch(32'hABCD_0000);
        cycles(4);
        check("R6", "level 5 after fetch", acc_cnt - base, 1);
        check("R3", "level 5 vector", last_vec, 32'h0000_1074);
        fetch(32'h0000_8000);

        ipl_i = 0; cycles(3);
        sr_write(16'h0000);
        vbr_write(32'h0000_2000);
        ipl_i = 3'd4; cycles(5);
        check("R7", "user-mode base write ignored", last_vec, 32'h0000_1070);
        fetch(32'h0000_9000);

        ipl_i = 0;
        sr_write(16'h2700);
        check("R9", "mask 7 written", mask_o, 7);
        base = acc_cnt;
        ipl_i = 3'd7; cycles(8);
        check("R5", "rise to 7 at mask 7", acc_cnt - base, 1);
        check("R3", "level 7 vector", last_vec, 32'h0000_107C);
        fetch(32'h0000_A000);
        base = acc_cnt;
        cycles(8);
        check("R5", "held 7 retrigger", acc_cnt - base, 0);
        ipl_i = 0; cycles(4);
        ipl_i = 3'd7; cycles(6);
        check("R5", "second rise to 7", acc_cnt - base, 1);
        fetch(32'h0000_B000);
        ipl_i = 0; cycles(4);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #40000;
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule